// File: doc/BRIEF.md
# Receive Mailbox Acceptance Matcher

This block takes the identifier of a received CAN frame and decides which receive mailbox gets it. Each mailbox presents a stored identifier and a free flag. Each mailbox also has an acceptance mask that marks which identifier bits must agree and which are ignored. Once the frame-valid pulse arrives, the matcher compares the identifier against every mailbox in parallel. A fixed number of cycles later it reports a done strobe, a hit flag and the index of the chosen mailbox.

Two masking schemes can be selected with a mode input. In per-mailbox mode, every mailbox has its own mask. In this mode an occupied mailbox is passed over in favour of a free one, so several mailboxes with the same filter form a queue. In the legacy scheme there is one shared mask, plus separate masks for mailboxes 14 and 15. The first matching mailbox wins even if it is occupied, so queueing is not available in that scheme. All masks are loaded through a small write port that honours the freeze input.

Top module: `mb_id_matcher`

## Requirements
- R1: A received identifier matches a mailbox when, for every mask bit at 1, the identifier bit equals the stored bit. Identifier bits under a mask bit at 0 are ignored.
- R2: With `indiv_en` = 1, mailbox k is filtered by the individual mask written at address k.
- R3: With `indiv_en` = 0, mailbox 14 uses the mask at address NUM_MB+1, mailbox 15 uses the mask at address NUM_MB+2, and every other mailbox uses the shared mask at address NUM_MB.
- R4: With `indiv_en` = 0, the result is the lowest-index matching mailbox, whatever its free flag.
- R5: With `indiv_en` = 1, occupied matching mailboxes (`mb_free` bit 0) are skipped, and the result is the lowest-index matching mailbox whose free flag is 1.
- R6: With `indiv_en` = 1, if every matching mailbox is occupied, `hit` is 1 and `mb_idx` is the highest-index matching mailbox.
- R7: When no mailbox matches, `hit` = 0 and `mb_idx` = 0 while `done` is high.
- R8: A write to an individual mask address (0 to NUM_MB-1) is ignored unless `indiv_en` = 1 and `freeze` = 1 at the write.
- R9: The three legacy masks reset to all ones (exact compare). A write to any of them is ignored unless `freeze` = 1.
- R10: `done` is high for one cycle, on the third rising edge counting the edge that samples `frame_valid`. The mailbox table, free flags, mode and masks are taken on the second of those edges. Out of reset, `done`, `hit` and `mb_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | One-cycle pulse: `rx_id` holds a received identifier |
| rx_id | input | ID_W | Received frame identifier |
| indiv_en | input | 1 | 1 = per-mailbox masks and queueing search; 0 = legacy three-mask scheme |
| freeze | input | 1 | Freeze state of the controller; gates mask writes |
| mb_id | input | NUM_MB*ID_W | Stored identifiers, mailbox k in bits [k*ID_W +: ID_W] |
| mb_free | input | NUM_MB | Bit k = 1 when mailbox k is free to receive |
| wr_en | input | 1 | Mask write strobe |
| wr_addr | input | AW | Mask address: 0..NUM_MB-1 individual, NUM_MB shared, NUM_MB+1 mailbox 14, NUM_MB+2 mailbox 15 |
| wr_data | input | ID_W | Mask value to write |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | A destination mailbox was found |
| mb_idx | output | IDX_W | Chosen mailbox index (0 when no hit) |

## Verification
The bench sweeps received identifiers over the whole stored-identifier range. It does this under both masking modes, two mask sets and several free-flag patterns. The table holds many duplicate identifiers, so several mailboxes match at once. A matcher that skipped occupied mailboxes in legacy mode, or that stopped at an occupied one in per-mailbox mode, would return the wrong index. So would one that reported the lowest instead of the last match when all candidates are occupied. Writes made outside freeze, or made in the wrong mode, each use a mask value that would make a mailbox catch an identifier no filter admits, so an ungated write shows up as a false hit. The legacy masks are exercised straight out of reset, which exposes a wrong reset value. The strobe is sampled around its single expected cycle, which exposes an off-by-one latency.

// File: rtl/mbm_pkg.sv
// Package: shared constants for the mailbox acceptance matcher.
// Assumes the mailbox bank holds at least 16 entries so that the two
// dedicated legacy-mask mailboxes exist.
package mbm_pkg;
    // Mailboxes that carry their own mask in the legacy scheme.
    localparam int LEG_A_IDX = 14;
    localparam int LEG_B_IDX = 15;
    // Masking scheme, taken from the mode input.
    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_INDIV  = 1'b1
    } mask_mode_e;
endpackage

// File: rtl/mbm_mask_bank.sv
// Module: mbm_mask_bank
// Holds the individual masks and the three legacy masks, and gates their
// writes. It drives the effective mask for each mailbox for the selected
// scheme. Assumes NUM_MB >= 16. Individual masks have no reset and stay
// undefined until written.
module mbm_mask_bank #(
    parameter int NUM_MB = 16,
    parameter int ID_W   = 11,
    parameter int AW     = 5,
    parameter int IDX_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [ID_W-1:0]          wr_data,
    input  logic                     indiv_en,
    input  logic                     freeze,
    output logic [NUM_MB*ID_W-1:0]   eff_mask
);
    import mbm_pkg::*;

    localparam logic [AW-1:0] ADDR_GLB = AW'(NUM_MB);
    localparam logic [AW-1:0] ADDR_LA  = AW'(NUM_MB + 1);
    localparam logic [AW-1:0] ADDR_LB  = AW'(NUM_MB + 2);

    logic [NUM_MB-1:0][ID_W-1:0] indiv_mem;
    logic [ID_W-1:0]             glb_mask, la_mask, lb_mask;
    logic                        indiv_wr_ok;

    assign indiv_wr_ok = wr_en && indiv_en && freeze && (wr_addr < ADDR_GLB);

    // Individual mask storage: written only when enabled and frozen, no reset.
    always_ff @(posedge clk) begin
        if (indiv_wr_ok) indiv_mem[wr_addr[IDX_W-1:0]] <= wr_data;
    end

    // Legacy masks: reset to exact compare, written only while frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_mask <= '1;
            la_mask  <= '1;
            lb_mask  <= '1;
        end else if (wr_en && freeze) begin
            if (wr_addr == ADDR_GLB) glb_mask <= wr_data;
            if (wr_addr == ADDR_LA)  la_mask  <= wr_data;
            if (wr_addr == ADDR_LB)  lb_mask  <= wr_data;
        end
    end

    // Effective mask per mailbox, picked by the scheme and the mailbox index.
    for (genvar k = 0; k < NUM_MB; k++) begin : g_eff
        logic [ID_W-1:0] legacy_sel;
        if (k == LEG_A_IDX) begin : g_la
            assign legacy_sel = la_mask;
        end else if (k == LEG_B_IDX) begin : g_lb
            assign legacy_sel = lb_mask;
        end else begin : g_glb
            assign legacy_sel = glb_mask;
        end
        assign eff_mask[k*ID_W +: ID_W] =
            (mask_mode_e'(indiv_en) == MODE_INDIV) ? indiv_mem[k] : legacy_sel;
    end

    AST_LEGACY_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && freeze) |=> $stable(glb_mask) && $stable(la_mask) && $stable(lb_mask)); // R9
endmodule

// File: rtl/mbm_match_vec.sv
// Module: mbm_match_vec
// Combinational compare of one identifier against every mailbox under its
// effective mask. Output bit k is set when mailbox k accepts the identifier.
// Assumes the inputs are registered upstream.
module mbm_match_vec #(
    parameter int NUM_MB = 16,
    parameter int ID_W   = 11
) (
    input  logic [ID_W-1:0]          rx_id,
    input  logic [NUM_MB*ID_W-1:0]   mb_id,
    input  logic [NUM_MB*ID_W-1:0]   eff_mask,
    output logic [NUM_MB-1:0]        match
);
    // One masked equality per mailbox: only bits under a 1 in the mask count.
    for (genvar k = 0; k < NUM_MB; k++) begin : g_cmp
        assign match[k] =
            ((rx_id ^ mb_id[k*ID_W +: ID_W]) & eff_mask[k*ID_W +: ID_W]) == '0;
    end
endmodule

// File: rtl/mbm_pick.sv
// Module: mbm_pick
// Chooses the destination mailbox from the match and free vectors and
// registers the result together with a one-cycle done strobe.
// Legacy: the lowest match wins. Individual: the lowest free match wins,
// otherwise the highest match is reported. Assumes single-cycle in_valid.
module mbm_pick #(
    parameter int NUM_MB = 16,
    parameter int IDX_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               indiv_mode,
    input  logic [NUM_MB-1:0]  match_i,
    input  logic [NUM_MB-1:0]  free_i,
    output logic               done_o,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Index of the lowest set bit (0 when none).
    function automatic logic [IDX_W-1:0] lowest(input logic [NUM_MB-1:0] v);
        lowest = '0;
        for (int i = NUM_MB - 1; i >= 0; i--) if (v[i]) lowest = IDX_W'(i);
    endfunction

    // Index of the highest set bit (0 when none).
    function automatic logic [IDX_W-1:0] highest(input logic [NUM_MB-1:0] v);
        highest = '0;
        for (int i = 0; i < NUM_MB; i++) if (v[i]) highest = IDX_W'(i);
    endfunction

    logic [NUM_MB-1:0] free_match;
    logic [IDX_W-1:0]  sel_idx;
    logic              sel_hit;

    assign free_match = match_i & free_i;

    // Selection rule per scheme, all three encoders in parallel.
    always_comb begin
        sel_hit = |match_i;
        if (!sel_hit)         sel_idx = '0;
        else if (!indiv_mode) sel_idx = lowest(match_i);
        else if (|free_match) sel_idx = lowest(free_match);
        else                  sel_idx = highest(match_i);
    end

    // Result register: strobe for one cycle, hold hit and index until next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            hit_o  <= 1'b0;
            idx_o  <= '0;
        end else begin
            done_o <= in_valid;
            if (in_valid) begin
                hit_o <= sel_hit;
                idx_o <= sel_idx;
            end
        end
    end

    AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !hit_o || |($past(match_i) & (NUM_MB'(1) << idx_o))); // R1
    AST_LEGACY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !indiv_mode && |match_i |=>
            ($past(match_i) & ((NUM_MB'(1) << idx_o) - NUM_MB'(1))) == '0); // R4
    AST_INDIV_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && indiv_mode && |(match_i & free_i) |=>
            |($past(match_i & free_i) & (NUM_MB'(1) << idx_o)) &&
            ($past(match_i & free_i) & ((NUM_MB'(1) << idx_o) - NUM_MB'(1))) == '0); // R5
    AST_NO_MATCH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && match_i == '0 |=> !hit_o && idx_o == '0); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done_o); // R10
endmodule

// File: rtl/mb_id_matcher.sv
// Module: mb_id_matcher (top)
// Three-stage matcher: capture the identifier, compare against all mailboxes,
// pick and register the result. Mailbox table, free flags and mode are taken
// in the compare stage and must be steady around it. Assumes NUM_MB >= 16.
module mb_id_matcher #(
    parameter int NUM_MB  = 16,
    parameter int ID_W    = 11,
    localparam int IDX_W  = $clog2(NUM_MB),
    localparam int AW     = $clog2(NUM_MB + 3)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_valid,
    input  logic [ID_W-1:0]         rx_id,
    input  logic                    indiv_en,
    input  logic                    freeze,
    input  logic [NUM_MB*ID_W-1:0]  mb_id,
    input  logic [NUM_MB-1:0]       mb_free,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [ID_W-1:0]         wr_data,
    output logic                    done,
    output logic                    hit,
    output logic [IDX_W-1:0]        mb_idx
);
    logic [NUM_MB*ID_W-1:0] eff_mask;
    logic [NUM_MB-1:0]      match_c, match_q, free_q;
    logic [ID_W-1:0]        id_q;
    logic                   v1_q, v2_q, mode_q;

    mbm_mask_bank #(.NUM_MB(NUM_MB), .ID_W(ID_W), .AW(AW), .IDX_W(IDX_W)) u_masks (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .indiv_en(indiv_en), .freeze(freeze),
        .eff_mask(eff_mask)
    );

    mbm_match_vec #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_cmp (
        .rx_id(id_q), .mb_id(mb_id), .eff_mask(eff_mask), .match(match_c)
    );

    // Stage 1: capture the received identifier with its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            id_q <= '0;
        end else begin
            v1_q <= frame_valid;
            if (frame_valid) id_q <= rx_id;
        end
    end

    // Stage 2: register the match vector, free flags and scheme.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q    <= 1'b0;
            match_q <= '0;
            free_q  <= '0;
            mode_q  <= 1'b0;
        end else begin
            v2_q <= v1_q;
            if (v1_q) begin
                match_q <= match_c;
                free_q  <= mb_free;
                mode_q  <= indiv_en;
            end
        end
    end

    mbm_pick #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .in_valid(v2_q), .indiv_mode(mode_q),
        .match_i(match_q), .free_i(free_q),
        .done_o(done), .hit_o(hit), .idx_o(mb_idx)
    );

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done && hit |-> int'(mb_idx) < NUM_MB); // R10
endmodule

// File: tb/test_mb_id_matcher.sv
module test_mb_id_matcher;
    localparam int CLK_PERIOD = 10;
    localparam int NMB = 16;
    localparam int IW  = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_valid = 1'b0;
    logic [IW-1:0] rx_id = '0;
    logic indiv_en = 1'b0;
    logic freeze = 1'b0;
    logic [NMB-1:0][IW-1:0] ids;
    logic [NMB-1:0] mb_free = '1;
    logic wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [IW-1:0] wr_data = '0;
    logic done, hit;
    logic [3:0] mb_idx;

    // Bench-side model of the mask contents.
    logic [IW-1:0] m_ind [NMB];
    logic [IW-1:0] m_glb, m_la, m_lb;

    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mb_id_matcher i_mb_id_matcher (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .rx_id(rx_id),
        .indiv_en(indiv_en), .freeze(freeze), .mb_id(ids), .mb_free(mb_free),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .hit(hit), .mb_idx(mb_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [IW-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Expected result computed from R1..R7.
    task automatic model(input logic [IW-1:0] rx, input bit mode,
                         output bit h, output int ix, output string req);
        int first_any = -1, first_free = -1, last_any = -1;
        for (int k = 0; k < NMB; k++) begin
            logic [IW-1:0] m;
            if (mode) m = m_ind[k];
            else if (k == 14) m = m_la;
            else if (k == 15) m = m_lb;
            else m = m_glb;
            if (((rx ^ ids[k]) & m) == '0) begin
                if (first_any < 0) first_any = k;
                if (first_free < 0 && mb_free[k]) first_free = k;
                last_any = k;
            end
        end
        h = (first_any >= 0);
        if (!h) begin ix = 0; req = "R7"; end
        else if (!mode) begin ix = first_any; req = "R1/R3/R4"; end
        else if (first_free >= 0) begin ix = first_free; req = "R1/R2/R5"; end
        else begin ix = last_any; req = "R1/R2/R6"; end
    endtask

    // Send one frame and check the result on the done cycle (R10 latency).
    task automatic frame(input logic [IW-1:0] rx);
        bit h; int ix; string req;
        model(rx, indiv_en, h, ix, req);
        @(negedge clk);
        frame_valid = 1'b1; rx_id = rx;
        @(negedge clk);
        frame_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(done === 1'b1 && hit === h && int'(mb_idx) == ix, req,
              {done, hit, 4'(mb_idx)}, {1'b1, h, 4'(ix)});
    endtask

    task automatic sweep();
        for (int r = 0; r < 17; r++) frame((r == 16) ? 11'h000 : 11'h2A0 + 11'(r));
    endtask

    initial begin
        for (int k = 0; k < NMB; k++) ids[k] = 11'h2A0 + 11'(k % 5);
        m_glb = '1; m_la = '1; m_lb = '1;
        for (int k = 0; k < NMB; k++) m_ind[k] = '1;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(done === 1'b0 && hit === 1'b0 && mb_idx === 4'd0, "R10 reset",
              {done, hit, mb_idx}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: legacy masks out of reset compare exactly; legacy ignores free (R4)
        indiv_en = 1'b0;
        mb_free = 16'h5555;
        sweep();

        // R10: single-cycle strobe on the third edge
        @(negedge clk);
        frame_valid = 1'b1; rx_id = 11'h2A1;
        @(negedge clk); frame_valid = 1'b0;
        check(done === 1'b0, "R10 early-1", done, 0);
        @(negedge clk);
        check(done === 1'b0, "R10 early-2", done, 0);
        @(negedge clk);
        check(done === 1'b1, "R10 on", done, 1);
        @(negedge clk);
        check(done === 1'b0, "R10 width", done, 0);

        for (int c = 0; c < 2; c++) begin
            // Load masks in freeze with individual masks enabled (R2, R9)
            freeze = 1'b1; indiv_en = 1'b1;
            for (int k = 0; k < NMB; k++) begin
                m_ind[k] = (c == 1 && (k % 3 == 0)) ? 11'h7FC : 11'h7FF;
                wr(k, m_ind[k]);
            end
            m_glb = (c == 0) ? 11'h7FE : 11'h7FC; wr(16, m_glb);
            m_la = 11'h7F0; wr(17, m_la);
            m_lb = (c == 0) ? 11'h7FF : 11'h7FE; wr(18, m_lb);

            // R8: individual write outside freeze ignored
            freeze = 1'b0; wr(0, 11'h000);
            // R8: individual write in freeze but legacy mode ignored
            freeze = 1'b1; indiv_en = 1'b0; wr(1, 11'h000);
            // R9: legacy write outside freeze ignored
            freeze = 1'b0; wr(16, 11'h000);
            mb_free = '1;
            indiv_en = 1'b1; frame(11'h7FF); // R8: would hit mailbox 0 or 1
            indiv_en = 1'b0; frame(11'h7FF); // R9: would hit mailbox 0

            for (int f = 0; f < 6; f++) begin
                case (f)
                    0: mb_free = 16'hFFFF;
                    1: mb_free = 16'h0000;
                    2: mb_free = 16'hAAAA;
                    3: mb_free = 16'h5555;
                    4: mb_free = 16'h00F0;
                    default: mb_free = 16'h8001;
                endcase
                for (int md = 0; md < 2; md++) begin
                    indiv_en = md[0];
                    sweep();
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule